// File: doc/BRIEF.md
# Clock Source Selector and Dividers

This block builds the three system clocks of a small low-power controller from three free-running source clocks: a slow crystal, a fast second crystal and the internal digitally controlled oscillator (DCO). The master clock drives the processor core and can take any of the three sources. The sub-master clock drives most peripherals and chooses between the DCO and the fast crystal. The auxiliary clock always comes from the slow crystal. Each output then passes through its own power-of-two divider and a run/stop gate.

Source changes use a two-stage handshake. The clock that is being left is switched off on its own falling edge before the clock that is being picked up is switched on on its own falling edge. Division is done by pulse swallowing. Each output pulse is a whole high phase of the selected source, and the gate enables are held in latches that are transparent only while their clock is low. This keeps runt pulses off the outputs when a select field, a divide field or a stop bit changes.

Three stop controls act on the outputs:
- A CPU-off bit halts the master clock, and an interrupt request lets it run again.
- A sub-master-off bit halts the peripheral clock.
- An oscillator-off bit halts the slow source, and with it the auxiliary clock.

The reset input is synchronous in every source domain. It must stay high for at least four periods of the slowest source.

Top module: `clk_sys_gen`

## Requirements
- R1: While reset is high, after its first few source edges, the outputs `mclk_o`, `smclk_o` and `aclk_o` stay low.
- R2: After reset, with every select and divide field at 0, `mclk_o` runs at the DCO period.
- R3: `mclk_sel_i` picks the master source as follows. Codes 2'b00 and 2'b01 select the DCO, 2'b10 selects the fast crystal and 2'b11 selects the slow crystal.
- R4: A divide field of value k (0 to 3) makes the rising edges of its output occur every 2^k source periods (divide by 1, 2, 4 or 8). Each high phase lasts exactly half a source period.
- R5: `smclk_sel_i` = 0 selects the DCO for the sub-master clock, and 1 selects the fast crystal.
- R6: `aclk_o` comes from the slow crystal, divided by `aclk_div_i`.
- R7: With `cpu_off_i` high and `irq_i` low, `mclk_o` stays low while `smclk_o` and `aclk_o` keep running. Clearing `cpu_off_i` restores `mclk_o`.
- R8: While `cpu_off_i` is high, raising `irq_i` restores `mclk_o` at its configured period. Lowering `irq_i` halts it again.
- R9: `smclk_off_i` high keeps `smclk_o` low and leaves `mclk_o` running.
- R10: `lfosc_off_i` high keeps `aclk_o` low and leaves `smclk_o` running. Clearing it restores `aclk_o`.
- R11: No output ever shows a high or low pulse shorter than half the fastest source period, including across changes of select, divide and stop controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dco_clk_i | input | 1 | Internal oscillator clock |
| hfx_clk_i | input | 1 | Fast (second) crystal clock |
| lfx_clk_i | input | 1 | Slow crystal clock |
| rst_i | input | 1 | Active-high reset, synchronous in every source domain |
| mclk_sel_i | input | 2 | Master clock source code |
| mclk_div_i | input | 2 | Master clock divide code |
| smclk_sel_i | input | 1 | Sub-master source: 0 DCO, 1 fast crystal |
| smclk_div_i | input | 2 | Sub-master divide code |
| aclk_div_i | input | 2 | Auxiliary divide code |
| cpu_off_i | input | 1 | Halt the master clock |
| irq_i | input | 1 | Interrupt request; lets the master clock run while halted |
| smclk_off_i | input | 1 | Halt the sub-master clock |
| lfosc_off_i | input | 1 | Halt the slow source |
| mclk_o | output | 1 | Master clock |
| smclk_o | output | 1 | Sub-master clock |
| aclk_o | output | 1 | Auxiliary clock |

## Verification
A select change completes after about two cycles of the old source plus two of the new source. A divide or stop change then needs two synchroniser cycles of the output's own source, plus up to one divided period. All of this stays within about twelve cycles of the slowest source involved. The bench therefore waits at least 1500 ns (over 37 slow-crystal periods) after every change. It then times two consecutive rising edges and the following falling edge of the output, and compares the period and the high width with source period times 2^k and half a source period. Stop checks wait 500 ns and then count output edges over an 800 ns window, which must be zero for the halted output and non-zero for the others. A monitor that runs throughout records the narrowest pulse on each output.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  localparam int DIV_W_DEF = 2;

  // master clock source codes (value is behaviour: decoded by the selector)
  typedef enum logic [1:0] {
    MSEL_DCO_A = 2'b00,
    MSEL_DCO_B = 2'b01,
    MSEL_HFX   = 2'b10,
    MSEL_LFX   = 2'b11
  } msel_e;

  // channel positions on the master selector input vector
  localparam int CH_DCO = 0;
  localparam int CH_HFX = 1;
  localparam int CH_LFX = 2;
  localparam int M_CHANNELS = 3;

  function automatic logic [1:0] msel_to_chan(input logic [1:0] code);
    case (msel_e'(code))
      MSEL_HFX: return 2'(CH_HFX);
      MSEL_LFX: return 2'(CH_LFX);
      default:  return 2'(CH_DCO);
    endcase
  endfunction

endpackage

// File: rtl/clk_cdc_sync.sv
module clk_cdc_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/clk_gf_mux.sv
module clk_gf_mux #(
  parameter int N   = 3,
  parameter int DEF = 0,
  parameter int SW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  clk_i,
  input  logic          rst_i,
  input  logic [SW-1:0] sel_i,
  output logic          clk_o
);

  logic [N-1:0] on_q;

  for (genvar i = 0; i < N; i++) begin : g_ch
    logic s1_r;
    logic on_r;
    logic others_off;

    assign others_off = ~|(on_q & ~(N'(1) << i));

    // request stage on the rising edge of this channel's clock
    always_ff @(posedge clk_i[i]) begin
      if (rst_i) s1_r <= (i == DEF);
      else       s1_r <= (sel_i == SW'(i)) && others_off;
    end

    // enable moves only while this clock is low
    always_ff @(negedge clk_i[i]) begin
      if (rst_i) on_r <= (i == DEF);
      else       on_r <= s1_r;
    end

    assign on_q[i] = on_r;
  end

  assign clk_o = |(clk_i & on_q);

  AST_CHAN_ONEHOT: assert property (@(posedge clk_i[DEF]) disable iff (rst_i)
    $onehot0(on_q)); // R11

endmodule

// File: rtl/clk_div_gate.sv
module clk_div_gate #(
  parameter int DIV_W  = clkgen_pkg::DIV_W_DEF,
  parameter bit RST_EN = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             clk_o
);

  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [DIV_W-1:0] div_s;
  logic             run_s;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;
  logic             tick;
  logic             en_q;
  logic             en_lat;

  clk_cdc_sync #(.W(DIV_W + 1), .STAGES(2), .RST_VAL('0)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   ({div_i, run_i}),
    .q_o   ({div_s, run_s})
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt <= '0;
    else       cnt <= cnt + 1'b1;
  end

  always_comb begin
    for (int b = 0; b < CNT_W; b++) mask[b] = (b < int'(div_s));
  end

  assign tick = ((cnt & mask) == mask);

  always_ff @(posedge clk_i) begin
    if (rst_i) en_q <= RST_EN;
    else       en_q <= tick & run_s;
  end

  always_latch begin
    if (!clk_i) en_lat = en_q;
  end

  assign clk_o = clk_i & en_lat;

  AST_LATCH_TRACK: assert property (@(posedge clk_i) disable iff (rst_i)
    en_lat == en_q); // R11

  AST_DIV_SPACING: assert property (@(posedge clk_i) disable iff (rst_i)
    en_q && ($past(div_s) != '0) && (div_s != '0) |=> !en_q); // R4

  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) && !$past(run_s) |-> !en_q); // R7

endmodule

// File: rtl/clk_sys_gen.sv
module clk_sys_gen
  import clkgen_pkg::*;
#(
  parameter int DIV_W = DIV_W_DEF
) (
  input  logic             dco_clk_i,
  input  logic             hfx_clk_i,
  input  logic             lfx_clk_i,
  input  logic             rst_i,
  input  logic [1:0]       mclk_sel_i,
  input  logic [DIV_W-1:0] mclk_div_i,
  input  logic             smclk_sel_i,
  input  logic [DIV_W-1:0] smclk_div_i,
  input  logic [DIV_W-1:0] aclk_div_i,
  input  logic             cpu_off_i,
  input  logic             irq_i,
  input  logic             smclk_off_i,
  input  logic             lfosc_off_i,
  output logic             mclk_o,
  output logic             smclk_o,
  output logic             aclk_o
);

  localparam int S_CHANNELS = 2;

  logic                  lf_clk;
  logic                  m_src;
  logic                  s_src;
  logic [M_CHANNELS-1:0] m_in;
  logic [S_CHANNELS-1:0] s_in;

  // slow source stop gate: runs through reset so its consumers can reset
  clk_div_gate #(.DIV_W(DIV_W), .RST_EN(1'b1)) u_lf_gate (
    .clk_i (lfx_clk_i),
    .rst_i (rst_i),
    .div_i ('0),
    .run_i (~lfosc_off_i),
    .clk_o (lf_clk)
  );

  always_comb begin
    m_in         = '0;
    m_in[CH_DCO] = dco_clk_i;
    m_in[CH_HFX] = hfx_clk_i;
    m_in[CH_LFX] = lf_clk;
  end

  assign s_in = {hfx_clk_i, dco_clk_i};

  clk_gf_mux #(.N(M_CHANNELS), .DEF(CH_DCO), .SW(2)) u_m_mux (
    .clk_i (m_in),
    .rst_i (rst_i),
    .sel_i (msel_to_chan(mclk_sel_i)),
    .clk_o (m_src)
  );

  clk_gf_mux #(.N(S_CHANNELS), .DEF(0), .SW(1)) u_s_mux (
    .clk_i (s_in),
    .rst_i (rst_i),
    .sel_i (smclk_sel_i),
    .clk_o (s_src)
  );

  clk_div_gate #(.DIV_W(DIV_W), .RST_EN(1'b0)) u_m_div (
    .clk_i (m_src),
    .rst_i (rst_i),
    .div_i (mclk_div_i),
    .run_i (~cpu_off_i | irq_i),
    .clk_o (mclk_o)
  );

  clk_div_gate #(.DIV_W(DIV_W), .RST_EN(1'b0)) u_s_div (
    .clk_i (s_src),
    .rst_i (rst_i),
    .div_i (smclk_div_i),
    .run_i (~smclk_off_i),
    .clk_o (smclk_o)
  );

  clk_div_gate #(.DIV_W(DIV_W), .RST_EN(1'b0)) u_a_div (
    .clk_i (lf_clk),
    .rst_i (rst_i),
    .div_i (aclk_div_i),
    .run_i (1'b1),
    .clk_o (aclk_o)
  );

endmodule

// File: tb/clk_sys_gen_tb.sv
`timescale 1ns/1ps
module clk_sys_gen_tb_top;

  logic dco_clk, hfx_clk, lfx_clk, rst;
  logic [1:0] mclk_sel, mclk_div, smclk_div, aclk_div;
  logic smclk_sel, cpu_off, irq, smclk_off, lfosc_off;
  logic mclk, smclk, aclk;

  int n_checks = 0;
  int n_errs   = 0;
  bit mon_on   = 1'b0;

  int m_edges = 0, s_edges = 0, a_edges = 0;
  real m_last = 0.0, s_last = 0.0, a_last = 0.0;
  real m_min = 1.0e9, s_min = 1.0e9, a_min = 1.0e9;

  localparam real DCO_P = 5.0;
  localparam real HFX_P = 8.0;
  localparam real LFX_P = 40.0;

  clk_sys_gen dut_i (
    .dco_clk_i   (dco_clk),
    .hfx_clk_i   (hfx_clk),
    .lfx_clk_i   (lfx_clk),
    .rst_i       (rst),
    .mclk_sel_i  (mclk_sel),
    .mclk_div_i  (mclk_div),
    .smclk_sel_i (smclk_sel),
    .smclk_div_i (smclk_div),
    .aclk_div_i  (aclk_div),
    .cpu_off_i   (cpu_off),
    .irq_i       (irq),
    .smclk_off_i (smclk_off),
    .lfosc_off_i (lfosc_off),
    .mclk_o      (mclk),
    .smclk_o     (smclk),
    .aclk_o      (aclk)
  );

  initial begin dco_clk = 1'b0; forever #2.5 dco_clk = ~dco_clk; end
  initial begin hfx_clk = 1'b0; #0.7; forever #4 hfx_clk = ~hfx_clk; end
  initial begin lfx_clk = 1'b0; #1.9; forever #20 lfx_clk = ~lfx_clk; end

  always @(posedge mclk)  m_edges++;
  always @(posedge smclk) s_edges++;
  always @(posedge aclk)  a_edges++;

  always @(mclk) begin
    if (mon_on && ($realtime - m_last) < m_min) m_min = $realtime - m_last;
    m_last = $realtime;
  end
  always @(smclk) begin
    if (mon_on && ($realtime - s_last) < s_min) s_min = $realtime - s_last;
    s_last = $realtime;
  end
  always @(aclk) begin
    if (mon_on && ($realtime - a_last) < a_min) a_min = $realtime - a_last;
    a_last = $realtime;
  end

  task automatic check_real(string req, string what, real act, real exp);
    n_checks++;
    if (act - exp > 0.01 || exp - act > 0.01) begin
      n_errs++;
      $display("FAIL %s %s actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic check_cnt(string req, string what, int act, bit want_zero);
    n_checks++;
    if (want_zero ? (act != 0) : (act == 0)) begin
      n_errs++;
      $display("FAIL %s %s actual %0d expected %s", req, what, act,
               want_zero ? "0" : "nonzero");
    end
  endtask

  task automatic measure(int which, output real per, output real hi);
    real t0, t1, t2;
    if (which == 0) begin
      @(posedge mclk); t0 = $realtime; @(posedge mclk); t1 = $realtime;
      @(negedge mclk); t2 = $realtime;
    end else if (which == 1) begin
      @(posedge smclk); t0 = $realtime; @(posedge smclk); t1 = $realtime;
      @(negedge smclk); t2 = $realtime;
    end else begin
      @(posedge aclk); t0 = $realtime; @(posedge aclk); t1 = $realtime;
      @(negedge aclk); t2 = $realtime;
    end
    per = t1 - t0;
    hi  = t2 - t1;
  endtask

  task automatic check_clk(string req, string what, int which, real src_p, int k);
    real per, hi;
    measure(which, per, hi);
    check_real(req, {what, " period"}, per, src_p * real'(1 << k));
    check_real(req, {what, " high"}, hi, src_p / 2.0);
  endtask

  task automatic window(output int dm, output int ds, output int da);
    int m0, s0, a0;
    m0 = m_edges; s0 = s_edges; a0 = a_edges;
    #800;
    dm = m_edges - m0; ds = s_edges - s0; da = a_edges - a0;
  endtask

  function automatic real msrc(int code);
    if (code == 2) return HFX_P;
    if (code == 3) return LFX_P;
    return DCO_P;
  endfunction

  task automatic finish_run();
    check_real("R11", "mclk narrowest pulse ok", (m_min >= 2.49) ? 1.0 : 0.0, 1.0);
    check_real("R11", "smclk narrowest pulse ok", (s_min >= 2.49) ? 1.0 : 0.0, 1.0);
    check_real("R11", "aclk narrowest pulse ok", (a_min >= 2.49) ? 1.0 : 0.0, 1.0);
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  endtask

  initial begin
    #600000;
    n_checks++;
    n_errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int dm, ds, da;
    rst = 1'b1;
    mclk_sel = 2'd0; mclk_div = 2'd0; smclk_sel = 1'b0; smclk_div = 2'd0;
    aclk_div = 2'd0; cpu_off = 1'b0; irq = 1'b0; smclk_off = 1'b0; lfosc_off = 1'b0;

    // R1: quiet outputs during reset
    #200;
    window(dm, ds, da);
    check_cnt("R1", "mclk edges in reset", dm, 1'b1);
    check_cnt("R1", "smclk edges in reset", ds, 1'b1);
    check_cnt("R1", "aclk edges in reset", da, 1'b1);
    #1;
    rst = 1'b0;

    // R2: default master source after reset
    #1500;
    check_clk("R2", "mclk default", 0, DCO_P, 0);
    mon_on = 1'b1;

    // R3 R4: master select and divide sweep
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 4; d++) begin
        mclk_sel = 2'(s); mclk_div = 2'(d);
        #1500;
        check_clk("R3 R4", $sformatf("mclk sel %0d div %0d", s, d), 0, msrc(s), d);
      end
    end
    mclk_sel = 2'd0; mclk_div = 2'd0;

    // R5 R4: sub-master select and divide sweep
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 4; d++) begin
        smclk_sel = 1'(s); smclk_div = 2'(d);
        #1500;
        check_clk("R5 R4", $sformatf("smclk sel %0d div %0d", s, d), 1,
                  (s == 1) ? HFX_P : DCO_P, d);
      end
    end
    smclk_sel = 1'b0; smclk_div = 2'd0;

    // R6 R4: auxiliary divide sweep
    for (int d = 0; d < 4; d++) begin
      aclk_div = 2'(d);
      #1500;
      check_clk("R6 R4", $sformatf("aclk div %0d", d), 2, LFX_P, d);
    end
    aclk_div = 2'd0;
    #1500;

    // R7: CPU-off halts only the master clock
    cpu_off = 1'b1;
    #500;
    window(dm, ds, da);
    check_cnt("R7", "mclk edges cpu off", dm, 1'b1);
    check_cnt("R7", "smclk edges cpu off", ds, 1'b0);
    check_cnt("R7", "aclk edges cpu off", da, 1'b0);

    // R8: interrupt request wakes the master clock
    irq = 1'b1;
    #500;
    check_clk("R8", "mclk irq wake", 0, DCO_P, 0);
    irq = 1'b0;
    #500;
    window(dm, ds, da);
    check_cnt("R8", "mclk edges irq gone", dm, 1'b1);
    cpu_off = 1'b0;
    #500;
    check_clk("R7", "mclk after cpu on", 0, DCO_P, 0);

    // R9: sub-master off
    smclk_off = 1'b1;
    #500;
    window(dm, ds, da);
    check_cnt("R9", "smclk edges off", ds, 1'b1);
    check_cnt("R9", "mclk edges smclk off", dm, 1'b0);
    smclk_off = 1'b0;
    #500;
    check_clk("R9", "smclk restored", 1, DCO_P, 0);

    // R10: slow oscillator off
    lfosc_off = 1'b1;
    #500;
    window(dm, ds, da);
    check_cnt("R10", "aclk edges osc off", da, 1'b1);
    check_cnt("R10", "smclk edges osc off", ds, 1'b0);
    lfosc_off = 1'b0;
    #1000;
    check_clk("R10", "aclk restored", 2, LFX_P, 0);

    finish_run();
  end

endmodule